// File: doc/BRIEF.md
# Paged Address Translation Cache

This block turns 32-bit logical addresses into physical addresses for a paged memory system. It keeps recently used page descriptors in two small, fully associative caches: one for data accesses and one for instruction fetches. Each request carries the logical address, the access direction, the access class and the privilege level. One cycle later the block answers with the physical address and the cache mode, or with a miss, or with a fault code.

The block does not walk page tables. On a miss, an external agent fetches the descriptor and loads it through the refill port, and the requester then retries the access. A refill replaces entries in round-robin order. If the refilled page is already cached, that entry is rewritten in place instead. A flush input empties both caches at once.

A clean hit sets the descriptor's used flag, and a write hit also sets its modified flag. The updated descriptor is offered on a write-back port for one cycle, so the memory copy can follow. A control word switches translation on or off and selects 4 KiB or 8 KiB pages while the block is running.

Top module: `pgx_xlate_top`

## Requirements
- R1: When control bit 15 is 0, each request answers with physical address equal to the logical address, fault code 00, hit 0, miss 0, cache mode 00, no write-back strobe, and no cached descriptor is changed.
- R2: Each request accepted at a rising edge produces exactly one response with rsp_valid_o high in the following cycle. After reset no response or write-back strobe is shown.
- R3: Control bit 14 selects the page size. With 0 (4 KiB), the physical address is descriptor bits 31:12 joined to logical bits 11:0. With 1 (8 KiB), it is descriptor bits 31:13 joined to logical bits 12:0, and page matching ignores logical bit 12.
- R4: A request with translation on and no matching entry in its class gives miss 1, hit 0, fault 00, no write-back strobe, and reads 0 on the physical address and the cache mode.
- R5: Descriptor layout: frame in bits 31:12, supervisor-only S in bit 9, cache mode in bits 8:7, modified M in bit 6, used U in bit 5, write-protect W in bit 4, type in bits 1:0. A clean hit outputs bits 8:7 as the cache mode (00 write-through, 01 copy-back, 10 serialized uncached, 11 uncached).
- R6: A hit on a descriptor of type 00 gives fault code 01 (translation fault).
- R7: A user-mode request (req_super_i = 0) hitting a descriptor with S = 1 gives fault code 11. A supervisor request to the same page is not faulted for privilege.
- R8: A write hitting a descriptor with W = 1 gives fault code 10. When several faults apply, 01 wins over 11, and 11 wins over 10.
- R9: A faulting hit gives hit 1, address and cache mode 0, and leaves the entry unchanged. A clean hit stores the descriptor with U set, and with M also set for a write. It pulses wb_valid_o for one cycle with that descriptor, the class and the logical address.
- R10: A flush empties every entry of both classes in one cycle. A request in the next cycle misses, and a refill in the same cycle as a flush is discarded.
- R11: Data and instruction entries are separate. A descriptor refilled for one class is never hit by requests of the other class.
- R12: Each class has ENTRIES entries. A refill of a page not present writes the slot under a round-robin pointer, which then advances modulo ENTRIES and restarts at 0 after reset or flush. A refill of a page already present (under the current page size) rewrites that entry and leaves the pointer alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 16 | Control word: bit 15 translation on, bit 14 8 KiB pages |
| flush_i | input | 1 | Invalidate all entries of both classes |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | 32 | Logical address |
| req_write_i | input | 1 | 1 = write access |
| req_instr_i | input | 1 | 1 = instruction class, 0 = data class |
| req_super_i | input | 1 | 1 = supervisor mode |
| fill_valid_i | input | 1 | Refill strobe |
| fill_instr_i | input | 1 | Class of the refilled entry |
| fill_addr_i | input | 32 | Logical address of the refilled page |
| fill_desc_i | input | 32 | Page descriptor to store |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_hit_o | output | 1 | An entry matched |
| rsp_miss_o | output | 1 | No entry matched |
| rsp_fault_o | output | 2 | 00 none, 01 translation, 10 write-protect, 11 privilege |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_cmode_o | output | 2 | Cache mode of the page |
| wb_valid_o | output | 1 | Updated descriptor strobe |
| wb_instr_o | output | 1 | Class of the updated entry |
| wb_desc_o | output | 32 | Descriptor with used/modified flags applied |
| wb_vaddr_o | output | 32 | Logical address that caused the update |

## Verification
Some rules are checked by the assertions on every cycle:
- pass-through with translation off;
- the one-cycle response timing;
- the untouched page-offset bits for both page sizes;
- a miss never carrying a fault or write-back;
- any write-back descriptor showing U, plus M for a write, never S for a user access, and never W for a write;
- a request right after a flush always missing.

Other behaviour depends on what the caches hold, so only the bench scenarios can show it. This covers:
- round-robin eviction after ENTRIES+1 refills;
- in-place rewrite of a page that is already cached;
- isolation between the two classes;
- fault priority on descriptors with several faulting bits;
- the flags persisting into later hits;
- 8 KiB matching across logical bit 12.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int VA_W    = 32;
    localparam int PG_LO   = 12;
    localparam int VPN_W   = VA_W - PG_LO;

    localparam int CTL_EN  = 15;
    localparam int CTL_BIG = 14;

    localparam int DS_SUP  = 9;
    localparam int DS_CMHI = 8;
    localparam int DS_CMLO = 7;
    localparam int DS_MOD  = 6;
    localparam int DS_USED = 5;
    localparam int DS_WP   = 4;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_XLATE = 2'b01,
        FLT_WPROT = 2'b10,
        FLT_PRIV  = 2'b11
    } flt_e;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [VA_W-1:0]  desc;
    } slot_t;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        flt_e            fault;
        logic [VA_W-1:0] paddr;
        logic [1:0]      cmode;
        logic            wb_valid;
        logic            wb_instr;
        logic [VA_W-1:0] wb_desc;
        logic [VA_W-1:0] wb_vaddr;
    } rsp_t;

    function automatic logic page_eq(input logic [VPN_W-1:0] a,
                                     input logic [VPN_W-1:0] b,
                                     input logic big);
        if (big)
            return a[VPN_W-1:1] == b[VPN_W-1:1];
        return a == b;
    endfunction

endpackage

// File: rtl/pgx_perm.sv
module pgx_perm
    import pgx_pkg::*;
(
    input  logic [VA_W-1:0] desc_i,
    input  logic            write_i,
    input  logic            super_i,
    output flt_e            fault_o,
    output logic [VA_W-1:0] desc_upd_o
);

    always_comb begin
        if (desc_i[1:0] == 2'b00)
            fault_o = FLT_XLATE;
        else if (!super_i && desc_i[DS_SUP])
            fault_o = FLT_PRIV;
        else if (write_i && desc_i[DS_WP])
            fault_o = FLT_WPROT;
        else
            fault_o = FLT_NONE;
    end

    always_comb begin
        desc_upd_o          = desc_i;
        desc_upd_o[DS_USED] = 1'b1;
        if (write_i)
            desc_upd_o[DS_MOD] = 1'b1;
    end

endmodule

// File: rtl/pgx_bank.sv
module pgx_bank
    import pgx_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             big_pg_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    output logic             lk_hit_o,
    output logic [IDX_W-1:0] lk_idx_o,
    output logic [VA_W-1:0]  lk_desc_o,
    input  logic             upd_en_i,
    input  logic [IDX_W-1:0] upd_idx_i,
    input  logic [VA_W-1:0]  upd_desc_i,
    input  logic             fill_en_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [VA_W-1:0]  fill_desc_i
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        slot_t [ENTRIES-1:0] slots;
        logic  [IDX_W-1:0]   rr;
    } bank_t;

    bank_t st_d, st_q;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    logic               fill_hit;
    logic [IDX_W-1:0]   fill_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]   = st_q.slots[g].vld &&
                               page_eq(st_q.slots[g].vpn, lk_vpn_i, big_pg_i);
        assign fill_match[g] = st_q.slots[g].vld &&
                               page_eq(st_q.slots[g].vpn, fill_vpn_i, big_pg_i);
    end

    // lowest matching index wins
    always_comb begin
        lk_hit_o = |lk_match;
        lk_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (lk_match[i])
                lk_idx_o = IDX_W'(i);
    end

    always_comb begin
        fill_hit = |fill_match;
        fill_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (fill_match[i])
                fill_idx = IDX_W'(i);
    end

    assign lk_desc_o = st_q.slots[lk_idx_o].desc;

    always_comb begin
        st_d = st_q;
        if (upd_en_i)
            st_d.slots[upd_idx_i].desc = upd_desc_i;
        if (fill_en_i) begin
            if (fill_hit) begin
                st_d.slots[fill_idx].vld  = 1'b1;
                st_d.slots[fill_idx].vpn  = fill_vpn_i;
                st_d.slots[fill_idx].desc = fill_desc_i;
            end else begin
                st_d.slots[st_q.rr].vld  = 1'b1;
                st_d.slots[st_q.rr].vpn  = fill_vpn_i;
                st_d.slots[st_q.rr].desc = fill_desc_i;
                st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
            end
        end
        if (flush_i) begin
            for (int i = 0; i < ENTRIES; i++)
                st_d.slots[i].vld = 1'b0;
            st_d.rr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/pgx_xlate_top.sv
module pgx_xlate_top
    import pgx_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] ctrl_i,
    input  logic        flush_i,
    input  logic        req_valid_i,
    input  logic [31:0] req_addr_i,
    input  logic        req_write_i,
    input  logic        req_instr_i,
    input  logic        req_super_i,
    input  logic        fill_valid_i,
    input  logic        fill_instr_i,
    input  logic [31:0] fill_addr_i,
    input  logic [31:0] fill_desc_i,
    output logic        rsp_valid_o,
    output logic        rsp_hit_o,
    output logic        rsp_miss_o,
    output logic [1:0]  rsp_fault_o,
    output logic [31:0] rsp_paddr_o,
    output logic [1:0]  rsp_cmode_o,
    output logic        wb_valid_o,
    output logic        wb_instr_o,
    output logic [31:0] wb_desc_o,
    output logic [31:0] wb_vaddr_o
);

    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CLASSES = 2;

    logic xl_en;
    logic big_pg;
    assign xl_en  = ctrl_i[CTL_EN];
    assign big_pg = ctrl_i[CTL_BIG];

    logic [CLASSES-1:0] cls_hit;
    logic [CLASSES-1:0] cls_upd;
    logic [IDX_W-1:0]   cls_idx  [CLASSES];
    logic [VA_W-1:0]    cls_desc [CLASSES];

    logic            sel_hit;
    logic [VA_W-1:0] sel_desc;
    flt_e            chk_fault;
    logic [VA_W-1:0] desc_upd;

    assign sel_hit  = cls_hit[req_instr_i];
    assign sel_desc = cls_desc[req_instr_i];

    pgx_perm u_perm (
        .desc_i     (sel_desc),
        .write_i    (req_write_i),
        .super_i    (req_super_i),
        .fault_o    (chk_fault),
        .desc_upd_o (desc_upd)
    );

    for (genvar c = 0; c < CLASSES; c++) begin : g_cls
        assign cls_upd[c] = req_valid_i && xl_en && (req_instr_i == 1'(c)) &&
                            cls_hit[c] && (chk_fault == FLT_NONE);

        pgx_bank #(.ENTRIES(ENTRIES)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush_i),
            .big_pg_i    (big_pg),
            .lk_vpn_i    (req_addr_i[VA_W-1:PG_LO]),
            .lk_hit_o    (cls_hit[c]),
            .lk_idx_o    (cls_idx[c]),
            .lk_desc_o   (cls_desc[c]),
            .upd_en_i    (cls_upd[c]),
            .upd_idx_i   (cls_idx[c]),
            .upd_desc_i  (desc_upd),
            .fill_en_i   (fill_valid_i && (fill_instr_i == 1'(c))),
            .fill_vpn_i  (fill_addr_i[VA_W-1:PG_LO]),
            .fill_desc_i (fill_desc_i)
        );
    end

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid_i;
        if (req_valid_i) begin
            if (!xl_en) begin
                rsp_d.paddr = req_addr_i;
            end else if (!sel_hit) begin
                rsp_d.miss = 1'b1;
            end else begin
                rsp_d.hit   = 1'b1;
                rsp_d.fault = chk_fault;
                if (chk_fault == FLT_NONE) begin
                    if (big_pg)
                        rsp_d.paddr = {sel_desc[VA_W-1:PG_LO+1], req_addr_i[PG_LO:0]};
                    else
                        rsp_d.paddr = {sel_desc[VA_W-1:PG_LO], req_addr_i[PG_LO-1:0]};
                    rsp_d.cmode    = sel_desc[DS_CMHI:DS_CMLO];
                    rsp_d.wb_valid = 1'b1;
                    rsp_d.wb_instr = req_instr_i;
                    rsp_d.wb_desc  = desc_upd;
                    rsp_d.wb_vaddr = req_addr_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_hit_o   = rsp_q.hit;
    assign rsp_miss_o  = rsp_q.miss;
    assign rsp_fault_o = rsp_q.fault;
    assign rsp_paddr_o = rsp_q.paddr;
    assign rsp_cmode_o = rsp_q.cmode;
    assign wb_valid_o  = rsp_q.wb_valid;
    assign wb_instr_o  = rsp_q.wb_instr;
    assign wb_desc_o   = rsp_q.wb_desc;
    assign wb_vaddr_o  = rsp_q.wb_vaddr;

endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] ctrl_i,
    input logic        flush_i,
    input logic        req_valid_i,
    input logic [31:0] req_addr_i,
    input logic        req_write_i,
    input logic        req_instr_i,
    input logic        req_super_i,
    input logic        fill_valid_i,
    input logic        fill_instr_i,
    input logic [31:0] fill_addr_i,
    input logic [31:0] fill_desc_i,
    input logic        rsp_valid_o,
    input logic        rsp_hit_o,
    input logic        rsp_miss_o,
    input logic [1:0]  rsp_fault_o,
    input logic [31:0] rsp_paddr_o,
    input logic [1:0]  rsp_cmode_o,
    input logic        wb_valid_o,
    input logic        wb_instr_o,
    input logic [31:0] wb_desc_o,
    input logic [31:0] wb_vaddr_o
);

    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);

    p_rsp_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i));

    p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !ctrl_i[15]) |=>
        (rsp_paddr_o == $past(req_addr_i) && rsp_fault_o == 2'b00 &&
         !rsp_miss_o && !rsp_hit_o && !wb_valid_o));

    p_small_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ctrl_i[15] && !ctrl_i[14]) |=>
        (!wb_valid_o || rsp_paddr_o[11:0] == $past(req_addr_i[11:0])));

    p_big_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ctrl_i[15] && ctrl_i[14]) |=>
        (!wb_valid_o || rsp_paddr_o[12:0] == $past(req_addr_i[12:0])));

    p_miss_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss_o |-> (!rsp_hit_o && rsp_fault_o == 2'b00 && !wb_valid_o));

    p_wb_cmode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> rsp_cmode_o == wb_desc_o[8:7]);

    p_wb_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> wb_desc_o[1:0] != 2'b00);

    p_user_super_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !$past(req_super_i)) |-> !wb_desc_o[9]);

    p_write_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && $past(req_write_i)) |-> (!wb_desc_o[4] && wb_desc_o[6]));

    p_wb_clean_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (rsp_hit_o && rsp_fault_o == 2'b00 && wb_desc_o[5] &&
                        wb_vaddr_o == $past(req_addr_i) &&
                        wb_instr_o == $past(req_instr_i)));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ctrl_i[15] && $past(flush_i)) |=> rsp_miss_o);

endmodule

bind pgx_xlate_top pgx_xlate_chk u_chk (.*);

// File: tb/pgx_xlate_top_tb.sv
`timescale 1ns/1ps
module pgx_xlate_top_tb;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl_i = '0;
    logic        flush_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic        req_write_i = 1'b0;
    logic        req_instr_i = 1'b0;
    logic        req_super_i = 1'b0;
    logic        fill_valid_i = 1'b0;
    logic        fill_instr_i = 1'b0;
    logic [31:0] fill_addr_i = '0;
    logic [31:0] fill_desc_i = '0;
    logic        rsp_valid_o, rsp_hit_o, rsp_miss_o;
    logic [1:0]  rsp_fault_o, rsp_cmode_o;
    logic [31:0] rsp_paddr_o;
    logic        wb_valid_o, wb_instr_o;
    logic [31:0] wb_desc_o, wb_vaddr_o;

    always #2 clk = ~clk;

    pgx_xlate_top #(.ENTRIES(N)) u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // reference state built from the requirements
    bit          m_vld  [2][N];
    logic [19:0] m_vpn  [2][N];
    logic [31:0] m_desc [2][N];
    int          m_rr   [2];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit same_page(logic [19:0] a, logic [19:0] b, bit big);
        return big ? (a[19:1] == b[19:1]) : (a == b);
    endfunction

    function automatic int m_find(int c, logic [19:0] v, bit big);
        for (int i = 0; i < N; i++)
            if (m_vld[c][i] && same_page(m_vpn[c][i], v, big))
                return i;
        return -1;
    endfunction

    function automatic void m_clear();
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < N; i++) m_vld[c][i] = 1'b0;
            m_rr[c] = 0;
        end
    endfunction

    function automatic void m_fill(int c, logic [19:0] v, logic [31:0] d, bit big);
        int k;
        k = m_find(c, v, big);
        if (k < 0) begin
            k = m_rr[c];
            m_rr[c] = (m_rr[c] + 1) % N;
        end
        m_vld[c][k] = 1'b1;
        m_vpn[c][k] = v;
        m_desc[c][k] = d;
    endfunction

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        m_clear();
    endtask

    task automatic do_fill(input bit c, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_instr_i = c; fill_addr_i = a; fill_desc_i = d;
        @(negedge clk);
        fill_valid_i = 1'b0;
        m_fill(int'(c), a[31:12], d, ctrl_i[14]);
    endtask

    task automatic do_req(input logic [31:0] a, input bit w, input bit c, input bit s);
        bit          en, big, e_hit, e_miss, e_wb;
        logic [1:0]  e_flt, e_cm;
        logic [31:0] e_pa, e_wbd, d;
        int          k;
        en = ctrl_i[15]; big = ctrl_i[14];
        e_hit = 0; e_miss = 0; e_wb = 0; e_flt = 2'b00; e_cm = 2'b00;
        e_pa = '0; e_wbd = '0; d = '0; k = -1;
        if (!en) begin
            e_pa = a;
        end else begin
            k = m_find(int'(c), a[31:12], big);
            if (k < 0) e_miss = 1;
            else begin
                d = m_desc[c][k];
                e_hit = 1;
                if (d[1:0] == 2'b00)      e_flt = 2'b01;
                else if (!s && d[9])      e_flt = 2'b11;
                else if (w && d[4])       e_flt = 2'b10;
                if (e_flt == 2'b00) begin
                    e_pa  = big ? {d[31:13], a[12:0]} : {d[31:12], a[11:0]};
                    e_cm  = d[8:7];
                    e_wb  = 1;
                    e_wbd = d | 32'h20 | (w ? 32'h40 : 32'h0);
                end
            end
        end
        @(negedge clk);
        req_valid_i = 1'b1; req_addr_i = a; req_write_i = w;
        req_instr_i = c; req_super_i = s;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(rsp_valid_o == 1'b1, "R2", "rsp_valid", 32'(rsp_valid_o), 32'd1);
        chk(rsp_hit_o == e_hit, "R2", "hit", 32'(rsp_hit_o), 32'(e_hit));
        chk(rsp_miss_o == e_miss, "R4", "miss", 32'(rsp_miss_o), 32'(e_miss));
        chk(rsp_fault_o == e_flt,
            (e_flt == 2'b01) ? "R6" : (e_flt == 2'b11) ? "R7" : "R8",
            "fault", 32'(rsp_fault_o), 32'(e_flt));
        chk(rsp_paddr_o == e_pa, en ? "R3" : "R1", "paddr", rsp_paddr_o, e_pa);
        chk(rsp_cmode_o == e_cm, "R5", "cmode", 32'(rsp_cmode_o), 32'(e_cm));
        chk(wb_valid_o == e_wb, "R9", "wb_valid", 32'(wb_valid_o), 32'(e_wb));
        if (e_wb) begin
            chk(wb_desc_o == e_wbd, "R9", "wb_desc", wb_desc_o, e_wbd);
            chk(wb_instr_o == c, "R9", "wb_instr", 32'(wb_instr_o), 32'(c));
            chk(wb_vaddr_o == a, "R9", "wb_vaddr", wb_vaddr_o, a);
            m_desc[c][k] = e_wbd;
        end
    endtask

    function automatic logic [31:0] mk_desc(logic [19:0] fr, logic [1:0] cm,
                                            bit sup, bit wp, logic [1:0] ty);
        return {fr, 2'b00, sup, cm, 1'b0, 1'b0, wp, 2'b00, ty};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        m_clear();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid_o == 1'b0, "R2", "reset rsp_valid", 32'(rsp_valid_o), 32'd0);
        chk(wb_valid_o == 1'b0, "R2", "reset wb_valid", 32'(wb_valid_o), 32'd0);

        // R1: translation off
        ctrl_i = 16'h0000;
        do_req(32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0);
        do_fill(1'b0, 32'h0001_2000, mk_desc(20'hABCDE, 2'b01, 0, 0, 2'b01));
        do_req(32'h0001_2345, 1'b0, 1'b0, 1'b1);

        // R4 miss, then refill and retry (R5, R9)
        ctrl_i = 16'h8000;
        do_req(32'h0005_5123, 1'b0, 1'b0, 1'b1);
        do_fill(1'b0, 32'h0005_5000, mk_desc(20'h7F3A1, 2'b10, 0, 0, 2'b10));
        do_req(32'h0005_5123, 1'b0, 1'b0, 1'b1);
        do_req(32'h0005_5FFC, 1'b1, 1'b0, 1'b0);
        chk(wb_desc_o[6:5] == 2'b11, "R9", "U and M after write", 32'(wb_desc_o[6:5]), 32'd3);
        do_req(32'h0001_2000, 1'b0, 1'b0, 1'b0);  // entry refilled while off: U still clear before
        // R1: the request made with translation off left U clear, so this first hit sets it fresh
        chk(wb_desc_o[5] == 1'b1, "R1", "U after enable", 32'(wb_desc_o[5]), 32'd1);

        // R6 / R7 / R8 and priorities
        do_fill(1'b0, 32'h0006_0000, mk_desc(20'h11111, 2'b00, 1, 1, 2'b00));
        do_req(32'h0006_0010, 1'b1, 1'b0, 1'b0);
        do_fill(1'b0, 32'h0007_0000, mk_desc(20'h22222, 2'b11, 1, 1, 2'b01));
        do_req(32'h0007_0010, 1'b1, 1'b0, 1'b0);
        chk(rsp_fault_o == 2'b11, "R8", "priv over wprot", 32'(rsp_fault_o), 32'd3);
        do_req(32'h0007_0010, 1'b1, 1'b0, 1'b1);
        chk(rsp_fault_o == 2'b10, "R8", "wprot for supervisor", 32'(rsp_fault_o), 32'd2);
        do_req(32'h0007_0010, 1'b0, 1'b0, 1'b1);
        chk(rsp_fault_o == 2'b00, "R7", "supervisor read ok", 32'(rsp_fault_o), 32'd0);

        // R11 class isolation
        do_req(32'h0005_5000, 1'b0, 1'b1, 1'b1);
        chk(rsp_miss_o == 1'b1, "R11", "instr sees no data entry", 32'(rsp_miss_o), 32'd1);
        do_fill(1'b1, 32'h0005_5000, mk_desc(20'h33333, 2'b01, 0, 0, 2'b01));
        do_req(32'h0005_5004, 1'b0, 1'b1, 1'b0);

        // R10 flush, and flush beating a same-cycle refill
        do_flush();
        do_req(32'h0005_5123, 1'b0, 1'b0, 1'b1);
        chk(rsp_miss_o == 1'b1, "R10", "miss after flush", 32'(rsp_miss_o), 32'd1);
        @(negedge clk);
        flush_i = 1'b1; fill_valid_i = 1'b1; fill_instr_i = 1'b0;
        fill_addr_i = 32'h0009_9000; fill_desc_i = mk_desc(20'h44444, 2'b00, 0, 0, 2'b01);
        @(negedge clk);
        flush_i = 1'b0; fill_valid_i = 1'b0;
        m_clear();
        do_req(32'h0009_9000, 1'b0, 1'b0, 1'b1);
        chk(rsp_miss_o == 1'b1, "R10", "fill dropped by flush", 32'(rsp_miss_o), 32'd1);

        // R3: 8 KiB pages, bit 12 from the logical address
        ctrl_i = 16'hC000;
        do_fill(1'b0, 32'h00A0_0000, mk_desc(20'h5555F, 2'b01, 0, 0, 2'b01));
        do_req(32'h00A0_1ABC, 1'b0, 1'b0, 1'b0);
        chk(rsp_paddr_o == 32'h5555_FABC, "R3", "8K paddr", rsp_paddr_o, 32'h5555_FABC);
        do_flush();

        // R12 round-robin eviction and in-place rewrite
        ctrl_i = 16'h8000;
        for (int i = 0; i <= N; i++)
            do_fill(1'b0, {20'h80000 + 20'(i), 12'h000}, mk_desc(20'(i), 2'b00, 0, 0, 2'b01));
        do_req(32'h8000_0000, 1'b0, 1'b0, 1'b1);
        chk(rsp_miss_o == 1'b1, "R12", "oldest evicted", 32'(rsp_miss_o), 32'd1);
        do_req(32'h8000_1000, 1'b0, 1'b0, 1'b1);
        chk(rsp_hit_o == 1'b1, "R12", "second kept", 32'(rsp_hit_o), 32'd1);
        do_fill(1'b0, 32'h8000_2000, mk_desc(20'h00777, 2'b11, 0, 0, 2'b01));
        do_fill(1'b0, 32'h9000_0000, mk_desc(20'h00888, 2'b00, 0, 0, 2'b01));
        do_req(32'h8000_1000, 1'b0, 1'b0, 1'b1);
        chk(rsp_miss_o == 1'b1, "R12", "pointer held on rewrite", 32'(rsp_miss_o), 32'd1);
        do_req(32'h8000_2000, 1'b0, 1'b0, 1'b1);
        chk(rsp_paddr_o == 32'h0077_7000, "R12", "rewritten entry", rsp_paddr_o, 32'h0077_7000);

        // random traffic on a small page pool
        do_flush();
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [31:0] a;
            logic [1:0]  ty;
            op = $urandom_range(0, 99);
            a  = {20'h12340 + 20'($urandom_range(0, 15) << 1) + 20'($urandom_range(0, 1)),
                  12'($urandom)};
            if (n == 1500) begin
                do_flush();
                ctrl_i[14] = 1'b1;
            end
            if (op < 30) begin
                ty = ($urandom_range(0, 7) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
                do_fill(1'($urandom), a,
                        mk_desc(20'($urandom), 2'($urandom),
                                $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, ty));
            end else if (op < 32) begin
                do_flush();
            end else if (op < 35) begin
                ctrl_i[15] = ~ctrl_i[15];
            end else begin
                do_req(a, 1'($urandom), 1'($urandom), 1'($urandom));
            end
        end
        finish_run();
    end

endmodule